// File: doc/BRIEF.md
# Indirect Interrupt Router Register Window

This block is the register file that software uses to program an I/O interrupt router. Two offsets face the bus. The select offset holds an 8-bit index. The window offset carries 32-bit data to and from whatever that index points at. The index can point at a read-only version word, a 4-bit identification word, or an arbitration word that mirrors the identification. It can also point at either half of a 64-bit redirection entry, and there is one such entry per interrupt input pin.

The full entry table is exported as a flat vector for the delivery logic. Each time the bus writes an entry, the block gives the delivery logic a one-cycle pulse. The pulse carries the entry index, the half that was written, and whether the mask bit flipped. The delivery logic sets and clears each entry's remote-IRR bit through per-pin inputs. A bus write to the low half of an entry always clears that bit.

Top module: `irr_route_regs`

## Requirements
- R1: A write to offset 0x00 stores bus_wdata[7:0] as the select value. A read at offset 0x00 returns the select value zero-extended.
- R2: With select 0x01, a window read returns (NUM_PINS-1) in bits 23:16 and VERSION_ID in bits 7:0, with all other bits zero. Window writes with that select change nothing.
- R3: With select 0x00, a window write stores bus_wdata[27:24] as the ID, and a window read returns the ID in bits 27:24 with all other bits zero. Select 0x02 reads the same word, and window writes with select 0x02 change nothing.
- R4: For select ≥ 0x10, the entry index is (select−0x10)>>1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0, for both reads and writes. Entry n occupies tbl_flat[64n+63:64n].
- R5: A window read whose entry index is ≥ NUM_PINS, or whose select is in 0x03..0x0F, returns 0xFFFFFFFF. A window write to such a select changes no state and gives no pulse.
- R6: A window write to the low half of an entry leaves that entry's remote-IRR bit (bit 14) at 0, whatever the data says. A write to the high half leaves bit 14 as it was.
- R7: After reset, the select value and the ID are 0, every entry reads 0 except for its mask bit (bit 16), which is 1, and bus_rdata is 0.
- R8: Reads at any offset other than 0x00 and 0x10 return 0. Writes at any such offset change nothing.
- R9: An accepted entry write raises ent_wr_pulse for exactly the cycle after the write, together with the index and the half. ent_mask_toggled is 1 in that cycle only when a low-half write changed bit 16.
- R10: rirr_set[n] sets bit 14 of entry n and rirr_clr[n] clears it, with set taking priority. A same-cycle low-half bus write to that entry takes priority over both.
- R11: Read data is registered and appears on bus_rdata in the cycle after bus_rd. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Offset inside the device range |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rirr_set | input | NUM_PINS | Per-pin remote-IRR set from delivery logic |
| rirr_clr | input | NUM_PINS | Per-pin remote-IRR clear from delivery logic |
| tbl_flat | output | 64*NUM_PINS | Whole redirection table |
| ent_wr_pulse | output | 1 | One-cycle pulse after an entry write |
| ent_wr_idx | output | IDX_W | Index of the written entry |
| ent_wr_upper | output | 1 | High half was written |
| ent_mask_toggled | output | 1 | Mask bit changed in that write |

## Verification
A wrong select register or a wrong index decode shows up on the first window read after the faulty select write. That read returns a neighbour's word, all ones, or a version word instead of the expected data, one cycle after bus_rd. A stale remote-IRR bit or a mask bit lost at reset appears both on tbl_flat in the cycle after the event and on the next low-half read. A missing or spurious change pulse is visible in the cycle directly after the write. The bench therefore compares every read against an independent model and checks the pulse fields right after each write.

// File: rtl/irr_pkg.sv
package irr_pkg;
    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_WIN  = 8'h10;
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL0 = 8'h10;
    localparam int ENT_W    = 64;
    localparam int RIRR_BIT = 14;
    localparam int MASK_BIT = 16;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_ENT,
        K_VOID
    } win_kind_t;
endpackage

// File: rtl/irr_sel_decode.sv
module irr_sel_decode
    import irr_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic [7:0]       sel,
    output win_kind_t        kind,
    output logic [IDX_W-1:0] idx,
    output logic             upper
);
    logic [7:0] off;
    logic [6:0] full_idx;

    always_comb begin
        off      = sel - SEL_TBL0;
        full_idx = off[7:1];
        upper    = off[0];
        idx      = '0;
        if (sel == SEL_ID)       kind = K_ID;
        else if (sel == SEL_VER) kind = K_VER;
        else if (sel == SEL_ARB) kind = K_ARB;
        else if (sel >= SEL_TBL0 && {1'b0, full_idx} < 8'(NUM_PINS)) begin
            kind = K_ENT;
            idx  = full_idx[IDX_W-1:0];
        end else begin
            kind = K_VOID;
        end
    end
endmodule

// File: rtl/irr_entry_table.sv
module irr_entry_table
    import irr_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_upper,
    input  logic [31:0]               wr_data,
    input  logic [NUM_PINS-1:0]       rirr_set,
    input  logic [NUM_PINS-1:0]       rirr_clr,
    output logic [NUM_PINS*ENT_W-1:0] tbl_flat,
    output logic                      ev_pulse,
    output logic [IDX_W-1:0]          ev_idx,
    output logic                      ev_upper,
    output logic                      ev_mask_tog
);
    localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << MASK_BIT;

    typedef struct packed {
        logic             pulse;
        logic [IDX_W-1:0] idx;
        logic             upper;
        logic             mask_tog;
    } ev_t;

    logic [NUM_PINS-1:0] mask_vec;
    ev_t ev_d, ev_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        logic [ENT_W-1:0] ent_d, ent_q;
        logic             hit;

        always_comb begin
            hit   = wr_en && (wr_idx == IDX_W'(i));
            ent_d = ent_q;
            if (rirr_clr[i]) ent_d[RIRR_BIT] = 1'b0;
            if (rirr_set[i]) ent_d[RIRR_BIT] = 1'b1;
            if (hit) begin
                if (wr_upper) begin
                    ent_d[63:32] = wr_data;
                end else begin
                    ent_d[31:0]     = wr_data;
                    ent_d[RIRR_BIT] = 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= ENT_RST;
            else        ent_q <= ent_d;
        end

        assign tbl_flat[i*ENT_W +: ENT_W] = ent_q;
        assign mask_vec[i] = ent_q[MASK_BIT];
    end

    always_comb begin
        ev_d.pulse    = wr_en;
        ev_d.idx      = wr_idx;
        ev_d.upper    = wr_upper;
        ev_d.mask_tog = wr_en && !wr_upper && (mask_vec[wr_idx] != wr_data[MASK_BIT]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign ev_pulse    = ev_q.pulse;
    assign ev_idx      = ev_q.idx;
    assign ev_upper    = ev_q.upper;
    assign ev_mask_tog = ev_q.mask_tog;
endmodule

// File: rtl/irr_route_regs.sv
module irr_route_regs
    import irr_pkg::*;
#(
    parameter int          NUM_PINS   = 24,
    parameter logic [7:0]  VERSION_ID = 8'h11,
    parameter int          IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PINS-1:0]       rirr_set,
    input  logic [NUM_PINS-1:0]       rirr_clr,
    output logic [NUM_PINS*64-1:0]    tbl_flat,
    output logic                      ent_wr_pulse,
    output logic [IDX_W-1:0]          ent_wr_idx,
    output logic                      ent_wr_upper,
    output logic                      ent_mask_toggled
);
    localparam logic [7:0]  LAST_PIN = 8'(NUM_PINS - 1);
    localparam logic [31:0] VER_WORD = {8'h00, LAST_PIN, 8'h00, VERSION_ID};

    typedef struct packed {
        logic [7:0]  sel;
        logic [3:0]  id;
        logic [31:0] rdata;
    } state_t;

    state_t           st_d, st_q;
    win_kind_t        kind;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_upper;
    logic             tbl_wr;
    logic [63:0]      ent_sel;
    logic [31:0]      win_rd;
    logic [7:0]       sel_cur;

    assign sel_cur = st_q.sel;

    irr_sel_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
        .sel   (st_q.sel),
        .kind  (kind),
        .idx   (dec_idx),
        .upper (dec_upper)
    );

    irr_entry_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (tbl_wr),
        .wr_idx      (dec_idx),
        .wr_upper    (dec_upper),
        .wr_data     (bus_wdata),
        .rirr_set    (rirr_set),
        .rirr_clr    (rirr_clr),
        .tbl_flat    (tbl_flat),
        .ev_pulse    (ent_wr_pulse),
        .ev_idx      (ent_wr_idx),
        .ev_upper    (ent_wr_upper),
        .ev_mask_tog (ent_mask_toggled)
    );

    always_comb begin
        ent_sel = tbl_flat[{dec_idx, 6'd0} +: 64];
        case (kind)
            K_VER:       win_rd = VER_WORD;
            K_ID, K_ARB: win_rd = {4'h0, st_q.id, 24'h0};
            K_ENT:       win_rd = dec_upper ? ent_sel[63:32] : ent_sel[31:0];
            default:     win_rd = 32'hFFFF_FFFF;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        tbl_wr = 1'b0;
        if (bus_wr && bus_addr == OFS_SEL) st_d.sel = bus_wdata[7:0];
        if (bus_wr && bus_addr == OFS_WIN) begin
            case (kind)
                K_ID:    st_d.id = bus_wdata[27:24];
                K_ENT:   tbl_wr  = 1'b1;
                default: ;
            endcase
        end
        if (bus_rd) begin
            case (bus_addr)
                OFS_SEL: st_d.rdata = {24'h0, st_q.sel};
                OFS_WIN: st_d.rdata = win_rd;
                default: st_d.rdata = 32'h0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/irr_regs_chk.sv
module irr_regs_chk
    import irr_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [7:0]             bus_addr,
    input logic [7:0]             wdata_lo,
    input logic [31:0]            bus_rdata,
    input logic [7:0]             sel,
    input logic [NUM_PINS*64-1:0] tbl_flat,
    input logic                   ent_wr_pulse,
    input logic [IDX_W-1:0]       ent_wr_idx,
    input logic                   ent_wr_upper,
    input logic                   ent_mask_toggled
);
    // R1: select write keeps the low byte
    p_sel_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_wr) && $past(bus_addr) == OFS_SEL |-> sel == $past(wdata_lo));

    // R5: out-of-table window read gives all ones
    p_oob_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_rd) && $past(bus_addr) == OFS_WIN && $past(sel) >= SEL_TBL0
        && (($past(sel) - SEL_TBL0) >> 1) >= 8'(NUM_PINS) |-> bus_rdata == 32'hFFFF_FFFF);

    // R6: low-half write leaves remote-IRR clear
    p_low_clears_rirr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr_pulse && !ent_wr_upper |-> !tbl_flat[{ent_wr_idx, 6'd14}]);

    // R8: other offsets read as zero
    p_other_ofs_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_rd) && $past(bus_addr) != OFS_SEL && $past(bus_addr) != OFS_WIN
        |-> bus_rdata == 32'h0);

    // R9: pulse only follows a window write
    p_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr_pulse |-> $past(bus_wr) && $past(bus_addr) == OFS_WIN);

    // R9: mask toggle only on a low-half write pulse
    p_mask_tog_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ent_mask_toggled |-> ent_wr_pulse && !ent_wr_upper);
endmodule

bind irr_route_regs irr_regs_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_wr           (bus_wr),
    .bus_rd           (bus_rd),
    .bus_addr         (bus_addr),
    .wdata_lo         (bus_wdata[7:0]),
    .bus_rdata        (bus_rdata),
    .sel              (sel_cur),
    .tbl_flat         (tbl_flat),
    .ent_wr_pulse     (ent_wr_pulse),
    .ent_wr_idx       (ent_wr_idx),
    .ent_wr_upper     (ent_wr_upper),
    .ent_mask_toggled (ent_mask_toggled)
);

// File: tb/test_irr_route_regs.sv
`timescale 1ns/1ps
module test_irr_route_regs;
    localparam int NP = 24;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] rirr_set = '0, rirr_clr = '0;
    logic [NP*64-1:0] tbl_flat;
    logic          ent_wr_pulse, ent_wr_upper, ent_mask_toggled;
    logic [IW-1:0] ent_wr_idx;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    irr_route_regs #(.NUM_PINS(NP), .VERSION_ID(8'h11)) i_irr_route_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rirr_set(rirr_set), .rirr_clr(rirr_clr), .tbl_flat(tbl_flat),
        .ent_wr_pulse(ent_wr_pulse), .ent_wr_idx(ent_wr_idx),
        .ent_wr_upper(ent_wr_upper), .ent_mask_toggled(ent_mask_toggled)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: read result appears the cycle after bus_rd (R11)
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(bus_rdata === e, t, {32'h0, bus_rdata}, {32'h0, e});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ev(input logic p, input int idx, input logic up, input logic tog, input string t);
        chk(ent_wr_pulse === p, t, {63'h0, ent_wr_pulse}, {63'h0, p});
        if (p) begin
            chk(ent_wr_idx === IW'(idx) && ent_wr_upper === up && ent_mask_toggled === tog, t,
                {ent_wr_idx, ent_wr_upper, ent_mask_toggled}, {IW'(idx), up, tog});
        end
    endtask

    task automatic pin_pulse(input int n, input bit setp);
        @(negedge clk);
        if (setp) rirr_set[n] = 1'b1; else rirr_clr[n] = 1'b1;
        @(negedge clk);
        rirr_set = '0; rirr_clr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        begin
            bit all_mask = 1, rest_zero = 1;
            for (int n = 0; n < NP; n++) begin
                if (tbl_flat[n*64 + 16] !== 1'b1) all_mask = 0;
                if ((tbl_flat[n*64 +: 64] & ~64'h10000) !== 64'h0) rest_zero = 0;
            end
            chk(all_mask && rest_zero, "R7 table reset", {62'h0, all_mask, rest_zero}, 64'h3);
            chk(bus_rdata === 32'h0, "R7 rdata reset", {32'h0, bus_rdata}, 64'h0);
        end
        rd(8'h00, 32'h0, "R7 select reset");
        rd(8'h10, 32'h0, "R7 id reset");
        // R1 select keeps low byte
        wr(8'h00, 32'h1234_5616);
        rd(8'h00, 32'h0000_0016, "R1 select readback");
        rd(8'h10, 32'h0001_0000, "R7 entry3 low reset mask");
        // R4/R6/R9 low write of entry 3, data bit14 set, mask cleared
        wr(8'h10, 32'hA5C0_4031);
        ev(1, 3, 0, 1, "R9 low write pulse");
        rd(8'h10, 32'hA5C0_0031, "R6 low write drops rirr");
        wr(8'h00, 32'h17);
        wr(8'h10, 32'hDEAD_BEEF);
        ev(1, 3, 1, 0, "R9 high write pulse");
        rd(8'h10, 32'hDEAD_BEEF, "R4 high readback");
        chk(tbl_flat[3*64 +: 64] === 64'hDEAD_BEEF_A5C0_0031, "R4 table slice",
            tbl_flat[3*64 +: 64], 64'hDEAD_BEEF_A5C0_0031);
        // R10 set from delivery logic
        pin_pulse(3, 1);
        chk(tbl_flat[3*64 + 14] === 1'b1, "R10 set", {63'h0, tbl_flat[3*64+14]}, 64'h1);
        wr(8'h10, 32'h0102_0304);  // high half keeps rirr
        rd(8'h00, 32'h17, "R1 select stable");
        wr(8'h00, 32'h16);
        rd(8'h10, 32'hA5C0_4031, "R6 high write keeps rirr");
        wr(8'h10, 32'h0001_4031);
        ev(1, 3, 0, 1, "R9 mask set toggles");
        rd(8'h10, 32'h0001_0031, "R6 low write clears rirr");
        pin_pulse(3, 1);
        pin_pulse(3, 0);
        rd(8'h10, 32'h0001_0031, "R10 clear");
        // R10 set wins over clear
        @(negedge clk); rirr_set[5] = 1'b1; rirr_clr[5] = 1'b1;
        @(negedge clk); rirr_set = '0; rirr_clr = '0;
        chk(tbl_flat[5*64 + 14] === 1'b1, "R10 set priority", {63'h0, tbl_flat[5*64+14]}, 64'h1);
        // R2 version
        wr(8'h00, 32'h01);
        rd(8'h10, 32'h0017_0011, "R2 version");
        wr(8'h10, 32'hFFFF_FFFF);
        ev(0, 0, 0, 0, "R2 version write no pulse");
        rd(8'h10, 32'h0017_0011, "R2 version read-only");
        // R3 id and arbitration
        wr(8'h00, 32'h00);
        wr(8'h10, 32'hF500_0000);
        rd(8'h10, 32'h0500_0000, "R3 id readback");
        wr(8'h00, 32'h02);
        rd(8'h10, 32'h0500_0000, "R3 arb mirrors id");
        wr(8'h10, 32'h0A00_0000);
        rd(8'h10, 32'h0500_0000, "R3 arb read-only");
        // R5 out of range
        wr(8'h00, 32'h40);
        rd(8'h10, 32'hFFFF_FFFF, "R5 index past table");
        wr(8'h10, 32'h0);
        ev(0, 0, 0, 0, "R5 write discarded");
        wr(8'h00, 32'h05);
        rd(8'h10, 32'hFFFF_FFFF, "R5 gap select");
        wr(8'h00, 32'hFF);
        rd(8'h10, 32'hFFFF_FFFF, "R5 top select");
        wr(8'h00, 32'h3E);
        rd(8'h10, 32'h0001_0000, "R5 last entry untouched");
        wr(8'h10, 32'h0000_0077);
        ev(1, 23, 0, 1, "R4 last entry write");
        rd(8'h10, 32'h0000_0077, "R4 last entry readback");
        // R8 other offsets
        rd(8'h20, 32'h0, "R8 other offset read");
        rd(8'h04, 32'h0, "R8 other offset read 2");
        wr(8'h20, 32'h33);
        rd(8'h00, 32'h3E, "R8 other offset write ignored");
        // R11 rdata holds without a read
        repeat (3) @(negedge clk);
        chk(bus_rdata === 32'h3E, "R11 rdata holds", {32'h0, bus_rdata}, 64'h3E);
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule